// File: doc/BRIEF.md
# Interrupt Source Coalescing State Bank

This block keeps the trigger state of a bank of interrupt sources. Each source holds a two-bit P/Q state and a mask bit. When a trigger arrives, the source decides from its state whether to pass an event on toward event routing, to remember it for later, or to drop it. A source that is waiting for its end-of-interrupt (EOI) does not forward again. One extra trigger in that window is held and is forwarded again when the EOI arrives. A dedicated P/Q code switches the source off without using its mask.

Each source is either message-signalled (MSI) or level-sensitive (LSI), set by a parameter. The trigger input of an MSI source counts one event for every cycle it is high. The trigger input of an LSI source is a line: a rising edge counts as an event, and a line still high at EOI counts as a fresh trigger. A small request port carries EOI, direct P/Q writes, mask writes and reads. Every request returns the values the source held before the request. Forwarded events leave on a strobe that carries the source number.

Top module: `pq_src_bank`

## Requirements
- R1: After reset every source reads P/Q = 01 (off) with mask = 1, and the forward strobe is low.
- R2: A trigger on a source in state 00 (ready) moves it to 10 (pending). The forward strobe then shows that source number in the cycle after the triggering clock edge.
- R3: A trigger on a pending source moves it to 11 (queued) and forwards nothing. A trigger on a queued or off source changes nothing and forwards nothing.
- R4: An EOI on a queued source moves it to pending and forwards the event again. An EOI on a pending source returns it to ready without forwarding. An EOI on a ready or off source has no effect.
- R5: While a source's mask is 1, it never forwards, but its P/Q transitions still take place. A mask write takes effect from the following cycle.
- R6: An MSI source counts an event in every cycle its trigger is high. An LSI source counts only a rising edge of its line.
- R7: When an LSI source receives an EOI while its line is high, the EOI is applied first and a trigger is then applied to the result.
- R8: Request codes are 0 read, 1 EOI, 2 write P/Q, 3 write mask. One cycle after a request, the response strobe is high and the response carries the P/Q and mask the source held before that request. A read changes nothing.
- R9: When a request and a trigger reach the same source in one cycle, the request is applied first and the trigger then acts on the result.
- R10: When several sources forward in the same cycle, their events leave one per cycle, lowest source number first, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | NUM_SRC | Per-source trigger pulse (MSI) or line (LSI) |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | Request code: 0 read, 1 EOI, 2 write P/Q, 3 write mask |
| req_src_i | input | SRC_W | Target source number |
| req_pq_i | input | 2 | P/Q value for a write P/Q request (bit 1 = P, bit 0 = Q) |
| req_mask_i | input | 1 | Mask value for a write mask request |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_pq_o | output | 2 | P/Q held before the request |
| rsp_mask_o | output | 1 | Mask held before the request |
| fwd_valid_o | output | 1 | Forward strobe toward event routing |
| fwd_src_o | output | SRC_W | Number of the forwarded source |

## Verification
The state machine is driven by isolated MSI pulses, by an MSI trigger held high for two cycles, and by an LSI line held high across several edges and across an EOI. Comparing the held MSI trigger with the held LSI line tells per-cycle counting apart from edge counting. The LSI EOI case tells a retrigger apart from a plain return to ready. Triggers sent to masked and off sources tell a mask suppression, which still advances P/Q, apart from an off state, which freezes P/Q. Requests that coincide with triggers on the same source, and a burst of three simultaneous triggers, check the ordering of same-cycle updates and the one-per-cycle forward order.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;

    // P/Q codes: bit 1 is P, bit 0 is Q
    typedef enum logic [1:0] {
        PQ_READY  = 2'b00,
        PQ_OFF    = 2'b01,
        PQ_PEND   = 2'b10,
        PQ_QUEUED = 2'b11
    } pq_e;

    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_EOI      = 2'd1,
        OP_SET_PQ   = 2'd2,
        OP_SET_MASK = 2'd3
    } op_e;

    typedef struct packed {
        pq_e  pq;
        logic fwd;
    } step_t;

    // Apply one trigger event to a P/Q state
    function automatic step_t trig_step(pq_e cur);
        step_t r;
        r.pq  = cur;
        r.fwd = 1'b0;
        case (cur)
            PQ_READY: begin r.pq = PQ_PEND;   r.fwd = 1'b1; end
            PQ_PEND:  begin r.pq = PQ_QUEUED; end
            default:  ;
        endcase
        return r;
    endfunction

    // Apply one end-of-interrupt to a P/Q state
    function automatic step_t eoi_step(pq_e cur);
        step_t r;
        r.pq  = cur;
        r.fwd = 1'b0;
        case (cur)
            PQ_QUEUED: begin r.pq = PQ_PEND; r.fwd = 1'b1; end
            PQ_PEND:   begin r.pq = PQ_READY; end
            default:   ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pq_src_cell.sv
module pq_src_cell
    import pq_src_pkg::*;
#(
    parameter bit IS_LSI = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic req_hit_i,
    input  op_e  req_op_i,
    input  pq_e  req_pq_i,
    input  logic req_mask_i,
    output pq_e  pq_o,
    output logic mask_o,
    output logic fire_o
);

    typedef struct packed {
        pq_e  pq;
        logic mask;
        logic line;
    } cell_t;

    cell_t cell_d, cell_q;
    logic  fire_d;

    always_comb begin
        step_t req_res;
        step_t trg_res;
        logic  evt;
        logic  retrig;

        cell_d      = cell_q;
        req_res.pq  = cell_q.pq;
        req_res.fwd = 1'b0;

        if (req_hit_i) begin
            case (req_op_i)
                OP_EOI:      req_res = eoi_step(cell_q.pq);
                OP_SET_PQ:   req_res.pq = req_pq_i;
                OP_SET_MASK: cell_d.mask = req_mask_i;
                default:     ;
            endcase
        end

        retrig = IS_LSI && req_hit_i && (req_op_i == OP_EOI) && trig_i;
        evt    = (IS_LSI ? (trig_i && !cell_q.line) : trig_i) || retrig;

        trg_res.pq  = req_res.pq;
        trg_res.fwd = 1'b0;
        if (evt) begin
            trg_res = trig_step(req_res.pq);
        end

        cell_d.pq   = trg_res.pq;
        cell_d.line = trig_i;
        fire_d      = (req_res.fwd || trg_res.fwd) && !cell_q.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q.pq   <= PQ_OFF;
            cell_q.mask <= 1'b1;
            cell_q.line <= 1'b0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign pq_o   = cell_q.pq;
    assign mask_o = cell_q.mask;
    assign fire_o = fire_d;

endmodule

// File: rtl/pq_fwd_arb.sv
module pq_fwd_arb #(
    parameter int NUM_SRC = 8,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               valid_o,
    output logic [SRC_W-1:0]   idx_o,
    output logic [NUM_SRC-1:0] grant_o
);

    always_comb begin
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = SRC_W'(i);
        end
        valid_o = |pend_i;
        grant_o = pend_i & (~pend_i + NUM_SRC'(1));
    end

endmodule

// File: rtl/pq_src_bank.sv
module pq_src_bank
    import pq_src_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter logic [NUM_SRC-1:0] LSI_MAP = 8'hF0,
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] trig_i,
    input  logic               req_valid_i,
    input  logic [1:0]         req_op_i,
    input  logic [SRC_W-1:0]   req_src_i,
    input  logic [1:0]         req_pq_i,
    input  logic               req_mask_i,
    output logic               rsp_valid_o,
    output logic [1:0]         rsp_pq_o,
    output logic               rsp_mask_o,
    output logic               fwd_valid_o,
    output logic [SRC_W-1:0]   fwd_src_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic               rsp_valid;
        logic [1:0]         rsp_pq;
        logic               rsp_mask;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [NUM_SRC-1:0][1:0] pq_vec;
    logic [NUM_SRC-1:0]      mask_vec;
    logic [NUM_SRC-1:0]      fire_vec;
    logic [NUM_SRC-1:0]      grant;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        pq_e  cell_pq;
        logic hit;

        assign hit       = req_valid_i && (req_src_i == SRC_W'(g));
        assign pq_vec[g] = cell_pq;

        pq_src_cell #(
            .IS_LSI (LSI_MAP[g])
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .trig_i     (trig_i[g]),
            .req_hit_i  (hit),
            .req_op_i   (op_e'(req_op_i)),
            .req_pq_i   (pq_e'(req_pq_i)),
            .req_mask_i (req_mask_i),
            .pq_o       (cell_pq),
            .mask_o     (mask_vec[g]),
            .fire_o     (fire_vec[g])
        );
    end

    pq_fwd_arb #(
        .NUM_SRC (NUM_SRC)
    ) u_arb (
        .pend_i  (bank_q.pend),
        .valid_o (fwd_valid_o),
        .idx_o   (fwd_src_o),
        .grant_o (grant)
    );

    always_comb begin
        bank_d           = bank_q;
        bank_d.pend      = (bank_q.pend & ~grant) | fire_vec;
        bank_d.rsp_valid = req_valid_i;
        if (req_valid_i) begin
            bank_d.rsp_pq   = pq_vec[req_src_i];
            bank_d.rsp_mask = mask_vec[req_src_i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.pend      <= '0;
            bank_q.rsp_valid <= 1'b0;
            bank_q.rsp_pq    <= PQ_OFF;
            bank_q.rsp_mask  <= 1'b1;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rsp_valid_o = bank_q.rsp_valid;
    assign rsp_pq_o    = bank_q.rsp_pq;
    assign rsp_mask_o  = bank_q.rsp_mask;

endmodule

// File: rtl/pq_src_bank_chk.sv
module pq_src_bank_chk #(
    parameter int NUM_SRC = 8,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid_i,
    input logic [SRC_W-1:0]        req_src_i,
    input logic                    rsp_valid_o,
    input logic [NUM_SRC-1:0][1:0] pq_vec,
    input logic [NUM_SRC-1:0]      mask_vec,
    input logic [NUM_SRC-1:0]      fire_vec
);

    // R8
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);

    // R8
    rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        logic hit;
        assign hit = req_valid_i && (req_src_i == SRC_W'(g));

        // R1
        off_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pq_vec[g] == 2'b01 && !hit) |=> pq_vec[g] == 2'b01);

        // R3
        queued_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pq_vec[g] == 2'b11 && !hit) |=> pq_vec[g] == 2'b11);

        // R5
        masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mask_vec[g] |-> !fire_vec[g]);
    end

endmodule

bind pq_src_bank pq_src_bank_chk #(
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_src_i   (req_src_i),
    .rsp_valid_o (rsp_valid_o),
    .pq_vec      (pq_vec),
    .mask_vec    (mask_vec),
    .fire_vec    (fire_vec)
);

// File: tb/sim_pq_src_bank.sv
`timescale 1ns/1ps
module sim_pq_src_bank;

    localparam int N = 8;
    localparam int SW = 3;
    localparam logic [1:0] RD = 2'd0, EOI = 2'd1, SPQ = 2'd2, SMK = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  trig = '0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [SW-1:0] req_src = '0;
    logic [1:0]    req_pq = '0;
    logic          req_mask = 1'b0;
    logic          rsp_valid_o, rsp_mask_o, fwd_valid_o;
    logic [1:0]    rsp_pq_o;
    logic [SW-1:0] fwd_src_o;

    int checks = 0;
    int errs = 0;
    logic [1:0] r_pq;
    logic       r_m, r_rv, r_fv;
    int         r_fs;

    always #4 clk = ~clk;

    pq_src_bank #(.NUM_SRC(N), .LSI_MAP(8'hF0)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig),
        .req_valid_i(req_valid), .req_op_i(req_op), .req_src_i(req_src),
        .req_pq_i(req_pq), .req_mask_i(req_mask),
        .rsp_valid_o(rsp_valid_o), .rsp_pq_o(rsp_pq_o), .rsp_mask_o(rsp_mask_o),
        .fwd_valid_o(fwd_valid_o), .fwd_src_o(fwd_src_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic grab();
        r_pq = rsp_pq_o; r_m = rsp_mask_o; r_rv = rsp_valid_o;
        r_fv = fwd_valid_o; r_fs = int'(fwd_src_o);
    endtask

    task automatic req_trig(input logic [1:0] op, input int src, input logic [1:0] pq,
                            input logic m, input logic [N-1:0] tv);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_src = SW'(src); req_pq = pq; req_mask = m;
        trig = trig | tv;
        @(negedge clk);
        req_valid = 1'b0;
        trig = trig & ~tv;
        grab();
    endtask

    task automatic req(input logic [1:0] op, input int src, input logic [1:0] pq, input logic m);
        req_trig(op, src, pq, m, '0);
    endtask

    task automatic pulse(input logic [N-1:0] tv);
        @(negedge clk);
        trig = trig | tv;
        @(negedge clk);
        trig = trig & ~tv;
        grab();
    endtask

    task automatic arm(input int src);
        req(SPQ, src, 2'b00, 1'b0);
        req(SMK, src, 2'b00, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 fwd idle", int'(fwd_valid_o), 0);
        chk("R1 rsp idle", int'(rsp_valid_o), 0);
        req(RD, 0, 2'b00, 1'b0);
        chk("R1 pq src0", int'(r_pq), 1);
        chk("R1 mask src0", int'(r_m), 1);
        chk("R8 rsp strobe", int'(r_rv), 1);
        req(RD, 5, 2'b00, 1'b0);
        chk("R1 pq src5", int'(r_pq), 1);
        chk("R1 mask src5", int'(r_m), 1);
    endtask

    task automatic t_msi_basic();
        req(SPQ, 2, 2'b00, 1'b0);
        chk("R8 write returns old pq", int'(r_pq), 1);
        req(SMK, 2, 2'b00, 1'b0);
        chk("R8 mask write returns old mask", int'(r_m), 1);
        pulse(8'h04);
        chk("R2 fwd valid", int'(r_fv), 1);
        chk("R2 fwd src", r_fs, 2);
        req(RD, 2, 2'b00, 1'b0);
        chk("R2 pending", int'(r_pq), 2);
        chk("R10 single fwd", int'(r_fv), 0);
        pulse(8'h04);
        chk("R3 no fwd when pending", int'(r_fv), 0);
        req(RD, 2, 2'b00, 1'b0);
        chk("R3 queued", int'(r_pq), 3);
        pulse(8'h04);
        chk("R3 no fwd when queued", int'(r_fv), 0);
        req(RD, 2, 2'b00, 1'b0);
        chk("R3 queued unchanged", int'(r_pq), 3);
        req(EOI, 2, 2'b00, 1'b0);
        chk("R4 eoi old pq", int'(r_pq), 3);
        chk("R4 replay fwd", int'(r_fv), 1);
        chk("R4 replay src", r_fs, 2);
        req(RD, 2, 2'b00, 1'b0);
        chk("R4 back to pending", int'(r_pq), 2);
        req(EOI, 2, 2'b00, 1'b0);
        chk("R4 no fwd from pending eoi", int'(r_fv), 0);
        req(RD, 2, 2'b00, 1'b0);
        chk("R4 ready after eoi", int'(r_pq), 0);
        req(EOI, 2, 2'b00, 1'b0);
        req(RD, 2, 2'b00, 1'b0);
        chk("R4 eoi on ready no effect", int'(r_pq), 0);
        chk("R4 eoi on ready no fwd", int'(r_fv), 0);
    endtask

    task automatic t_off();
        req(SMK, 3, 2'b00, 1'b0);
        pulse(8'h08);
        chk("R3 off no fwd", int'(r_fv), 0);
        req(EOI, 3, 2'b00, 1'b0);
        chk("R4 off eoi no fwd", int'(r_fv), 0);
        req(RD, 3, 2'b00, 1'b0);
        chk("R4 off stays off", int'(r_pq), 1);
    endtask

    task automatic t_mask();
        req(SPQ, 1, 2'b00, 1'b0);
        pulse(8'h02);
        chk("R5 masked no fwd", int'(r_fv), 0);
        req(RD, 1, 2'b00, 1'b0);
        chk("R5 masked still pending", int'(r_pq), 2);
        chk("R5 mask reads 1", int'(r_m), 1);
        pulse(8'h02);
        req(RD, 1, 2'b00, 1'b0);
        chk("R5 masked queued", int'(r_pq), 3);
        req(SMK, 1, 2'b00, 1'b0);
        req(EOI, 1, 2'b00, 1'b0);
        chk("R5 unmasked replay fwd", int'(r_fv), 1);
        chk("R5 unmasked replay src", r_fs, 1);
    endtask

    task automatic t_msi_hold();
        arm(0);
        @(negedge clk); trig[0] = 1'b1;
        @(negedge clk); grab();
        chk("R6 msi held fwd", int'(r_fv), 1);
        chk("R6 msi held src", r_fs, 0);
        @(negedge clk); trig[0] = 1'b0;
        req(RD, 0, 2'b00, 1'b0);
        chk("R6 msi counts each cycle", int'(r_pq), 3);
    endtask

    task automatic t_lsi();
        arm(4);
        @(negedge clk); trig[4] = 1'b1;
        @(negedge clk); grab();
        chk("R6 lsi edge fwd", int'(r_fv), 1);
        chk("R6 lsi edge src", r_fs, 4);
        repeat (3) @(negedge clk);
        req(RD, 4, 2'b00, 1'b0);
        chk("R6 lsi level counted once", int'(r_pq), 2);
        req(EOI, 4, 2'b00, 1'b0);
        chk("R7 lsi eoi old pq", int'(r_pq), 2);
        chk("R7 lsi retrigger fwd", int'(r_fv), 1);
        chk("R7 lsi retrigger src", r_fs, 4);
        req(RD, 4, 2'b00, 1'b0);
        chk("R7 lsi pending again", int'(r_pq), 2);
        @(negedge clk); trig[4] = 1'b0;
        req(EOI, 4, 2'b00, 1'b0);
        chk("R7 lsi low eoi no fwd", int'(r_fv), 0);
        req(RD, 4, 2'b00, 1'b0);
        chk("R7 lsi ready", int'(r_pq), 0);
    endtask

    task automatic t_same_cycle();
        req_trig(SPQ, 2, 2'b01, 1'b0, 8'h04);
        chk("R9 old pq on write", int'(r_pq), 0);
        chk("R9 off first then trigger no fwd", int'(r_fv), 0);
        req(RD, 2, 2'b00, 1'b0);
        chk("R9 off kept", int'(r_pq), 1);
        req(SPQ, 2, 2'b00, 1'b0);
        pulse(8'h04);
        chk("R9 setup fwd", int'(r_fv), 1);
        req_trig(EOI, 2, 2'b00, 1'b0, 8'h04);
        chk("R9 eoi then trigger fwd", int'(r_fv), 1);
        chk("R9 eoi then trigger src", r_fs, 2);
        req(RD, 2, 2'b00, 1'b0);
        chk("R9 pending after both", int'(r_pq), 2);
    endtask

    task automatic t_multi();
        req(SPQ, 0, 2'b00, 1'b0);
        req(SPQ, 2, 2'b00, 1'b0);
        req(SPQ, 3, 2'b00, 1'b0);
        pulse(8'h0D);
        chk("R10 first valid", int'(r_fv), 1);
        chk("R10 first src", r_fs, 0);
        @(negedge clk); grab();
        chk("R10 second src", r_fs, 2);
        @(negedge clk); grab();
        chk("R10 third src", r_fs, 3);
        @(negedge clk); grab();
        chk("R10 drained", int'(r_fv), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_msi_basic();
        t_off();
        t_mask();
        t_msi_hold();
        t_lsi();
        t_same_cycle();
        t_multi();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule